// File: doc/BRIEF.md
# High-Side Driver Fault Diagnostic Monitor

This block watches the raw fault comparators of two high-side drivers and a junction temperature sensor. It turns them into an 8-bit diagnostic word that a serial host interface can read. The host starts a diagnostic run by setting the start bit of its control register, in either normal or test mode. The block then waits one qualification window. It qualifies every fault that is valid for the selected mode and keeps tracking those faults until the mode changes or a driver is switched off. A fault counts only after it has been present without a break for the whole window. It leaves the word only after it has been absent for the same length of time.

Each change of a warning bit pulls the active-low interrupt line low. At the same time the block asks for the start bit to be set again, so that the host knows a fresh read is due. A read of the diagnostic word releases the interrupt and asks for the start bit to be cleared. If a new change lands in the same cycle as the read, the new change wins. The serial shifter and the analog sensing sit outside this block.

The sequencer has three states:
- `ST_IDLE`: qualifiers held clear, word frozen.
- `ST_WINDOW`: first qualification window after a start.
- `ST_MONITOR`: continuous tracking.

Its transitions are:
- **start accepted**: `ST_IDLE` to `ST_WINDOW`. This happens when the start bit is set and either test mode is on or both drivers are enabled.
- **window elapsed**: `ST_WINDOW` to `ST_MONITOR`, after `QUAL_CYCLES` cycles.
- **abort**: `ST_WINDOW` or `ST_MONITOR` to `ST_IDLE`. This happens when test mode differs from the mode latched at start, or when a normal-mode run loses a driver enable.

Top module: `hsd_diag_monitor`

## Requirements
- R1: The diagnostic word has this bit layout: bit 7 is the mode the last accepted start ran in (1 = test). Bits 6, 5 and 4 are driver 1 overcurrent, open load and short to supply. Bits 3, 2 and 1 are the same three flags for driver 2. Bit 0 is the over-temperature warning.
- R2: In a normal-mode run (bit 7 = 0) only overcurrent (bits 6 and 3) and over-temperature (bit 0) can be reported. Bits 5, 4, 2 and 1 read 0.
- R3: In a test-mode run (bit 7 = 1) only open load, short to supply (bits 5, 4, 2, 1) and over-temperature can be reported. Bits 6 and 3 read 0.
- R4: A fault bit sets only after its raw input has been present for `QUAL_CYCLES` consecutive cycles (default 100 µs at `CLK_FREQ_HZ`). A shorter pulse, or one broken by a single absent cycle, leaves the bit at 0, because the count restarts on each drop.
- R5: A set fault bit clears only after its raw input has been absent for `QUAL_CYCLES` consecutive cycles.
- R6: Any change of bits 6..0, from 0 to 1 or from 1 to 0, while tracking drives `irq_n_o` low and produces a one-cycle `start_set_o` pulse.
- R7: A one-cycle `diag_rd_i` pulse releases `irq_n_o` to 1 and produces a one-cycle `start_clr_o` pulse.
- R8: A read in the same cycle as a new bit change leaves `irq_n_o` low, pulses `start_set_o` and does not pulse `start_clr_o`.
- R9: A normal-mode start while either driver enable is 0 is ignored. The word does not change and no interrupt is raised.
- R10: After reset the word is 0x00, `irq_n_o` is 1 and both request pulses are 0.
- R11: After an abort, fault inputs stop affecting the word, and the word holds its last value until the next accepted start.
- R12: An accepted start clears bits 6..0 and loads bit 7 with the test-mode input, without raising the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode_i | input | 1 | Test-mode control bit |
| start_i | input | 1 | Start-diagnostic control bit (level) |
| drv1_on_i | input | 1 | Driver 1 enable control bit |
| drv2_on_i | input | 1 | Driver 2 enable control bit |
| drv1_oc_i | input | 1 | Driver 1 raw overcurrent flag |
| drv1_ol_i | input | 1 | Driver 1 raw open-load flag |
| drv1_sc_i | input | 1 | Driver 1 raw short-to-supply flag |
| drv2_oc_i | input | 1 | Driver 2 raw overcurrent flag |
| drv2_ol_i | input | 1 | Driver 2 raw open-load flag |
| drv2_sc_i | input | 1 | Driver 2 raw short-to-supply flag |
| overtemp_i | input | 1 | Raw junction over-temperature flag |
| diag_rd_i | input | 1 | One-cycle pulse: diagnostic word was read |
| diag_o | output | 8 | Diagnostic word |
| irq_n_o | output | 1 | Interrupt request, 0 = pulled low |
| start_set_o | output | 1 | One-cycle request to set the start bit |
| start_clr_o | output | 1 | One-cycle request to clear the start bit |

## Verification
The bench targets these corner cases:
- **Short and broken pulses.** Fault pulses a few cycles shorter than the window, and a pulse split by a single absent cycle, must leave the word alone. A qualifier that failed to restart its count would set the bit anyway.
- **Read colliding with a change.** A read is placed exactly in the cycle where a bit changes. A tracker that let the read win would release the interrupt and lose the event.
- **Mode masking and ignored starts.** Overcurrent flags are raised during test mode and open-load flags during normal mode. A normal start is attempted with one driver off. A monitor that did not mask by mode, or did not gate the start, would report invalid faults or update the word.
- **Frozen word after an abort.** The word must stay unchanged while inputs move after an abort. A monitor that kept tracking would change it.

Random fault vectors, preceded by random short glitches, check that transients shorter than the window never leak into the word or the interrupt.

// File: rtl/hsd_diag_pkg.sv
package hsd_diag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WINDOW  = 2'd1,
        ST_MONITOR = 2'd2
    } diag_state_e;

    // Warning vector index equals diagnostic word bit position.
    localparam int unsigned NUM_WARN = 7;
    localparam int unsigned MODE_BIT = 7;

    localparam int unsigned IDX_THERM = 0;
    localparam int unsigned IDX_D2_SC = 1;
    localparam int unsigned IDX_D2_OL = 2;
    localparam int unsigned IDX_D2_OC = 3;
    localparam int unsigned IDX_D1_SC = 4;
    localparam int unsigned IDX_D1_OL = 5;
    localparam int unsigned IDX_D1_OC = 6;

    // Faults that are meaningful in each mode.
    localparam logic [NUM_WARN-1:0] VALID_NORMAL = 7'b100_1001;
    localparam logic [NUM_WARN-1:0] VALID_TEST   = 7'b011_0111;

    function automatic logic [NUM_WARN-1:0] mode_valid(input logic test_mode);
        return test_mode ? VALID_TEST : VALID_NORMAL;
    endfunction

endpackage

// File: rtl/hsd_fault_qualifier.sv
module hsd_fault_qualifier #(
    parameter int unsigned QUAL_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic raw_i,
    output logic q_o
);

    localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] run_len_q;
    logic          level_q;

    // Qualified level flips only after the raw input disagrees with it
    // for QUAL_CYCLES consecutive cycles; any agreement restarts the count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
            level_q   <= 1'b0;
        end else if (!run_i) begin
            run_len_q <= '0;
            level_q   <= 1'b0;
        end else if (raw_i == level_q) begin
            run_len_q <= '0;
        end else if (run_len_q == LAST) begin
            run_len_q <= '0;
            level_q   <= raw_i;
        end else begin
            run_len_q <= run_len_q + 1'b1;
        end
    end

    assign q_o = level_q;

    // R4
    qual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_o) |-> ($past(raw_i) && $past(run_i)));

    // R5
    qual_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q_o) && $past(run_i)) |-> !$past(raw_i));

    // R11
    qual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !q_o);

endmodule

// File: rtl/hsd_diag_fsm.sv
module hsd_diag_fsm
    import hsd_diag_pkg::*;
#(
    parameter int unsigned QUAL_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic test_mode_i,
    input  logic drv1_on_i,
    input  logic drv2_on_i,
    output logic run_o,
    output logic track_o,
    output logic load_o,
    output logic mode_o
);

    localparam int unsigned WCW = $clog2(QUAL_CYCLES + 1);
    localparam logic [WCW-1:0] WIN_LAST = WCW'(QUAL_CYCLES - 1);

    diag_state_e    state_q, state_d;
    logic [WCW-1:0] win_cnt_q;
    logic           mode_q;
    logic           drivers_on;
    logic           start_ok;
    logic           keep_ok;

    assign drivers_on = drv1_on_i & drv2_on_i;
    assign start_ok   = start_i & (test_mode_i | drivers_on);
    assign keep_ok    = (test_mode_i == mode_q) & (mode_q | drivers_on);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (!keep_ok)                   state_d = ST_IDLE;
                else if (win_cnt_q == WIN_LAST) state_d = ST_MONITOR;
            end
            ST_MONITOR: begin
                if (!keep_ok) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Window counter and latched mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
            mode_q    <= 1'b0;
        end else begin
            if (state_q == ST_WINDOW) win_cnt_q <= win_cnt_q + 1'b1;
            else                      win_cnt_q <= '0;
            if (state_q == ST_IDLE && start_ok) mode_q <= test_mode_i;
        end
    end

    // Outputs
    always_comb begin
        run_o   = 1'b0;
        track_o = 1'b0;
        load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:    load_o  = start_ok;
            ST_WINDOW:  run_o   = 1'b1;
            ST_MONITOR: begin
                run_o   = 1'b1;
                track_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign mode_o = mode_q;

    // R9
    ignored_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !test_mode_i && !(drv1_on_i && drv2_on_i))
        |=> state_q == ST_IDLE);

    // R4
    window_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MONITOR |-> $past(state_q) != ST_IDLE);

    // R11
    mode_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && test_mode_i != mode_q) |=> state_q == ST_IDLE);

endmodule

// File: rtl/hsd_irq_tracker.sv
module hsd_irq_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic rd_i,
    output logic irq_n_o,
    output logic set_o,
    output logic clr_o
);

    logic pend_q;
    logic set_q;
    logic clr_q;

    // A change always wins over a read in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            set_q  <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            pend_q <= chg_i | (pend_q & ~rd_i);
            set_q  <= chg_i;
            clr_q  <= rd_i & ~chg_i;
        end
    end

    assign irq_n_o = ~pend_q;
    assign set_o   = set_q;
    assign clr_o   = clr_q;

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !chg_i) |=> (irq_n_o && clr_o));

    // R8
    read_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && chg_i) |=> (!irq_n_o && set_o && !clr_o));

    // R6
    set_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |-> !irq_n_o);

endmodule

// File: rtl/hsd_diag_monitor.sv
module hsd_diag_monitor
    import hsd_diag_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ  = 50_000_000,
    parameter int unsigned QUAL_TIME_US = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_mode_i,
    input  logic       start_i,
    input  logic       drv1_on_i,
    input  logic       drv2_on_i,
    input  logic       drv1_oc_i,
    input  logic       drv1_ol_i,
    input  logic       drv1_sc_i,
    input  logic       drv2_oc_i,
    input  logic       drv2_ol_i,
    input  logic       drv2_sc_i,
    input  logic       overtemp_i,
    input  logic       diag_rd_i,
    output logic [7:0] diag_o,
    output logic       irq_n_o,
    output logic       start_set_o,
    output logic       start_clr_o
);

    localparam int unsigned QUAL_CYCLES_RAW = (CLK_FREQ_HZ / 1000) * QUAL_TIME_US / 1000;
    localparam int unsigned QUAL_CYCLES     = (QUAL_CYCLES_RAW < 2) ? 2 : QUAL_CYCLES_RAW;

    logic                run;
    logic                track;
    logic                load;
    logic                mode;
    logic [NUM_WARN-1:0] raw_vec;
    logic [NUM_WARN-1:0] gated_vec;
    logic [NUM_WARN-1:0] qual_vec;
    logic [7:0]          diag_q;
    logic                warn_chg;

    always_comb begin
        raw_vec            = '0;
        raw_vec[IDX_THERM] = overtemp_i;
        raw_vec[IDX_D2_SC] = drv2_sc_i;
        raw_vec[IDX_D2_OL] = drv2_ol_i;
        raw_vec[IDX_D2_OC] = drv2_oc_i;
        raw_vec[IDX_D1_SC] = drv1_sc_i;
        raw_vec[IDX_D1_OL] = drv1_ol_i;
        raw_vec[IDX_D1_OC] = drv1_oc_i;
    end

    assign gated_vec = raw_vec & mode_valid(mode);

    hsd_diag_fsm #(
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .test_mode_i (test_mode_i),
        .drv1_on_i   (drv1_on_i),
        .drv2_on_i   (drv2_on_i),
        .run_o       (run),
        .track_o     (track),
        .load_o      (load),
        .mode_o      (mode)
    );

    for (genvar gi = 0; gi < NUM_WARN; gi++) begin : g_qual
        hsd_fault_qualifier #(
            .QUAL_CYCLES (QUAL_CYCLES)
        ) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .run_i (run),
            .raw_i (gated_vec[gi]),
            .q_o   (qual_vec[gi])
        );
    end

    assign warn_chg = track & (qual_vec != diag_q[NUM_WARN-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diag_q <= '0;
        end else if (load) begin
            diag_q <= {test_mode_i, {NUM_WARN{1'b0}}};
        end else if (track) begin
            diag_q[NUM_WARN-1:0] <= qual_vec;
        end
    end

    hsd_irq_tracker u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg_i   (warn_chg),
        .rd_i    (diag_rd_i),
        .irq_n_o (irq_n_o),
        .set_o   (start_set_o),
        .clr_o   (start_clr_o)
    );

    assign diag_o = diag_q;

    // R2
    normal_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_o[MODE_BIT] |-> (diag_o[IDX_D1_OL] == 1'b0 && diag_o[IDX_D1_SC] == 1'b0 &&
                               diag_o[IDX_D2_OL] == 1'b0 && diag_o[IDX_D2_SC] == 1'b0));

    // R3
    test_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diag_o[MODE_BIT] |-> (diag_o[IDX_D1_OC] == 1'b0 && diag_o[IDX_D2_OC] == 1'b0));

    // R6
    irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> diag_o[6:0] != $past(diag_o[6:0]));

    // R12
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (diag_o[6:0] == 7'd0 && !start_set_o));

endmodule

// File: tb/hsd_diag_monitor_bench.sv
module hsd_diag_monitor_bench;

    localparam int Q = 20;  // 200 kHz nominal x 100 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 0, start = 0, drv1_on = 0, drv2_on = 0;
    logic oc1 = 0, ol1 = 0, sc1 = 0, oc2 = 0, ol2 = 0, sc2 = 0, ot = 0;
    logic diag_rd = 0;
    logic [7:0] diag;
    logic irq_n, start_set, start_clr;

    int checks = 0, errors = 0;
    int set_cnt = 0, clr_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hsd_diag_monitor #(
        .CLK_FREQ_HZ  (200_000),
        .QUAL_TIME_US (100)
    ) u_hsd_diag_monitor (
        .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode), .start_i(start),
        .drv1_on_i(drv1_on), .drv2_on_i(drv2_on),
        .drv1_oc_i(oc1), .drv1_ol_i(ol1), .drv1_sc_i(sc1),
        .drv2_oc_i(oc2), .drv2_ol_i(ol2), .drv2_sc_i(sc2),
        .overtemp_i(ot), .diag_rd_i(diag_rd),
        .diag_o(diag), .irq_n_o(irq_n), .start_set_o(start_set), .start_clr_o(start_clr)
    );

    always @(negedge clk) if (rst_n) begin
        if (start_set) set_cnt++;
        if (start_clr) clr_cnt++;
    end

    function automatic logic [6:0] expect_bits(logic [6:0] raw, logic tm);
        return raw & (tm ? 7'b011_0111 : 7'b100_1001);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // order {oc1, ol1, sc1, oc2, ol2, sc2, ot} = bits 6..0
    task automatic set_raw(logic [6:0] v);
        {oc1, ol1, sc1, oc2, ol2, sc2, ot} = v;
    endtask

    task automatic do_read;
        diag_rd = 1; cyc(1); diag_rd = 0; cyc(1);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic random_phase(logic tm, inout logic [6:0] prev, input int iters);
        for (int it = 0; it < iters; it++) begin
            logic [6:0] nv = 7'($urandom);
            logic [6:0] gl = 7'($urandom);
            int k = 1 + int'($urandom % (Q - 5));
            int s0 = set_cnt;
            logic [6:0] ex;
            set_raw(gl); cyc(k);
            set_raw(nv); cyc(Q + 6);
            ex = expect_bits(nv, tm);
            chk(tm ? "R3 random word" : "R2 random word", diag, {tm, ex});
            chk("R6 random irq", irq_n, (ex == prev) ? 1 : 0);
            chk("R6 random set pulse", (set_cnt > s0) ? 1 : 0, (ex != prev) ? 1 : 0);
            do_read;
            chk("R7 random release", irq_n, 1);
            prev = ex;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [6:0] prev;
        int s0, c0;
        void'($urandom(32'h5EED));
        cyc(5);
        // R10
        chk("R10 reset word", diag, 8'h00);
        chk("R10 reset irq", irq_n, 1);
        chk("R10 reset pulses", {start_set, start_clr}, 0);
        rst_n = 1; cyc(2);

        // R9: normal start with driver 2 off
        drv1_on = 1; drv2_on = 0; start = 1;
        set_raw(7'b110_0001);
        cyc(Q + 10);
        chk("R9 ignored word", diag, 8'h00);
        chk("R9 ignored irq", irq_n, 1);

        // R1 R2: accepted normal start
        drv2_on = 1;
        cyc(Q + 10);
        chk("R1 R2 normal word", diag, 8'h41);
        chk("R6 irq on commit", irq_n, 0);
        chk("R6 set pulse", (set_cnt > 0) ? 1 : 0, 1);
        c0 = clr_cnt;
        do_read; start = 0;
        chk("R7 read release", irq_n, 1);
        chk("R7 clear pulse", clr_cnt, c0 + 1);

        // R4: short and broken pulses on driver 2 overcurrent
        s0 = set_cnt;
        set_raw(7'b100_1001); cyc(Q - 4);
        set_raw(7'b100_0001); cyc(Q + 5);
        chk("R4 short pulse", diag, 8'h41);
        set_raw(7'b100_1001); cyc(Q - 4);
        set_raw(7'b100_0001); cyc(1);
        set_raw(7'b100_1001); cyc(Q - 4);
        set_raw(7'b100_0001); cyc(Q + 5);
        chk("R4 broken pulse", diag, 8'h41);
        chk("R4 no irq", irq_n, 1);
        chk("R4 no set pulse", set_cnt, s0);
        set_raw(7'b100_1001); cyc(Q + 6);
        chk("R4 held fault", diag, 8'h49);
        chk("R6 irq rise", irq_n, 0);
        do_read;

        // R8: read in the exact cycle of a change
        s0 = set_cnt; c0 = clr_cnt;
        set_raw(7'b100_1000); cyc(Q);
        diag_rd = 1; cyc(1); diag_rd = 0; cyc(1);
        chk("R8 word", diag, 8'h48);
        chk("R8 irq held", irq_n, 0);
        chk("R8 set pulse", set_cnt, s0 + 1);
        chk("R8 no clear", clr_cnt, c0);
        do_read;
        chk("R7 release after collide", irq_n, 1);

        // R5: fault removal
        set_raw(7'b000_1000); cyc(Q + 6);
        chk("R5 cleared bit", diag, 8'h08);
        chk("R6 irq on fall", irq_n, 0);
        do_read;
        prev = 7'b000_1000;

        random_phase(1'b0, prev, 12);

        // R11: abort by dropping a driver, word frozen
        drv1_on = 0; cyc(2);
        s0 = set_cnt;
        set_raw(prev ^ 7'b100_1001); cyc(Q + 6);
        chk("R11 frozen word", diag, {1'b0, prev});
        chk("R11 no irq", irq_n, 1);
        chk("R11 no set", set_cnt, s0);

        // R3 R12: test-mode start (drivers irrelevant)
        set_raw(7'b110_0010);
        test_mode = 1; start = 1; cyc(2);
        chk("R12 cleared on start", diag, 8'h80);
        chk("R12 quiet start", irq_n, 1);
        cyc(Q + 6);
        chk("R1 R3 test word", diag, 8'hA2);
        chk("R6 test irq", irq_n, 0);
        do_read; start = 0;
        prev = 7'b010_0010;

        random_phase(1'b1, prev, 12);

        done = 1;
        summary();
    end

endmodule